// File: doc/BRIEF.md
# Keyboard Scan Code Decoder

This block sits behind a serial keyboard receiver and turns its stream of set-2 scan code bytes into key events. The receiver hands over one byte per cycle in which `code_valid` is high. The two prefix bytes are absorbed and never reach the output. The byte 0xE0 marks an extended key and 0xF0 marks a key release. They are kept as pending flags, and the next real scan code carries them.

For each real key event the block presents the scan code, the extended flag, the released flag and an ASCII equivalent that follows the state of the shift keys. Both shift keys are tracked, and their combined state is visible on `shift_on`. When the `TRAP_SHIFT` parameter is non-zero, shift key presses and releases update that state but produce no event. The result stays on the output registers and `key_ready` stays high until the consumer pulses `read_ack`.

Top module: `kbd_scan_decoder`

## Requirements
- R1: A valid byte of 0xE0 sets a pending extended flag. It produces no event, so `key_ready` and the output fields stay unchanged.
- R2: A valid byte of 0xF0 sets a pending released flag. It produces no event, so `key_ready` and the output fields stay unchanged.
- R3: A valid byte other than 0xE0 and 0xF0 is a key event. Both pending flags clear in the cycle after it, whether or not the event reaches the output. An event that reaches the output drives `key_code` with the byte, and `key_ext` and `key_rel` with the flags that were pending for it.
- R4: Scan code 0x12 is the left shift key and 0x59 is the right shift key. A code without a pending release marks that key as held, and a code with a pending release marks it as free. `shift_on` is high while either key is held.
- R5: Letter keys give lowercase ASCII when `shift_on` is low and uppercase ASCII when it is high. For example, 0x1C gives 0x61 or 0x41. The state before the current byte applies.
- R6: Tab (0x0D) gives 0x09, Enter (0x5A) gives 0x0D, Space (0x29) gives 0x20, and digit 1 (0x16) gives 0x31, or 0x21 when shifted. A code with no mapping gives 0x00 while its scan code is still reported, and so does any code that carries the extended flag.
- R7: With `TRAP_SHIFT` non-zero, bytes 0x12 and 0x59 produce no output event. `key_ready` and the output fields are unchanged, but R3 still clears the pending flags.
- R8: With `TRAP_SHIFT` zero, shift key codes appear on `key_code` like any other key, with ASCII 0x00.
- R9: An output event sets `key_ready` in the next cycle. It stays high until a cycle with `read_ack` high and no output event, and then goes low. An event in the same cycle as `read_ack` leaves it high.
- R10: `rst_n` low at a clock edge clears the pending flags, the shift state, all outputs and `key_ready`.
- R11: Outside an output event, `key_code`, `key_ascii`, `key_ext` and `key_rel` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_valid | input | 1 | `code_byte` holds a received byte this cycle |
| code_byte | input | 8 | Scan code byte from the receiver |
| read_ack | input | 1 | Consumer has taken the current event |
| key_ready | output | 1 | An unread key event is on the outputs |
| key_code | output | 8 | Scan code of the last event |
| key_ascii | output | 8 | ASCII equivalent, 0x00 if none |
| key_ext | output | 1 | Last event was preceded by 0xE0 |
| key_rel | output | 1 | Last event was preceded by 0xF0 |
| shift_on | output | 1 | Either shift key is held |

## Verification
The bound checker checks on every cycle that the handshake behaves correctly: prefix bytes and trapped shift codes leave `key_ready` and the fields untouched, `read_ack` without a byte drops `key_ready`, and idle cycles hold the fields. It also checks that the pending flags clear after any key event and that a shift press raises `shift_on`. The ASCII values, the pairing of each prefix with the right key, and the difference between the trapping and non-trapping builds can only be shown by the bench's byte sequences. The bench feeds both builds the same stream, covering a sweep of all byte values, all letters with each shift key, and mixed prefix sequences.

// File: rtl/kbd_dec_pkg.sv
// Shared constants and widths for the keyboard scan code decoder.
// Assumes set-2 scan codes, one byte wide.
package kbd_dec_pkg;
    localparam int unsigned CODE_W    = 8;
    localparam int unsigned ASCII_W   = 8;
    localparam logic [CODE_W-1:0] EXT_PREFIX = 8'hE0;
    localparam logic [CODE_W-1:0] REL_PREFIX = 8'hF0;
    localparam logic [CODE_W-1:0] LSHIFT_CODE = 8'h12;
    localparam logic [CODE_W-1:0] RSHIFT_CODE = 8'h59;
    localparam int unsigned NUM_SHIFT = 2;
    localparam logic [ASCII_W-1:0] CASE_DELTA = 8'h20;

    // Scan codes of the shift keys, indexed by key
    function automatic logic [CODE_W-1:0] shift_code(input int unsigned idx);
        return (idx == 0) ? LSHIFT_CODE : RSHIFT_CODE;
    endfunction
endpackage

// File: rtl/kbd_prefix_hold.sv
// Pending prefix flags.
// Sets the extended or released flag when the matching prefix byte arrives.
// Clears both after any key event, including one that produces no output.
// Assumes that a prefix byte and a key event never occur in the same cycle.
module kbd_prefix_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_seen,
    input  logic rel_seen,
    input  logic key_evt,
    output logic ext_pend,
    output logic rel_pend
);
    // Track the extended prefix until the key it belongs to arrives
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_pend <= 1'b0;
        else if (key_evt)  ext_pend <= 1'b0;
        else if (ext_seen) ext_pend <= 1'b1;
    end

    // Track the release prefix until the key it belongs to arrives
    always_ff @(posedge clk) begin
        if (!rst_n)        rel_pend <= 1'b0;
        else if (key_evt)  rel_pend <= 1'b0;
        else if (rel_seen) rel_pend <= 1'b1;
    end
endmodule

// File: rtl/kbd_shift_track.sv
// Shift key state.
// Keeps one held bit per shift key. A key event with its code sets the bit,
// or clears it if a release prefix is pending. shift_on is the OR of the bits.
// Assumes that key_evt is high only for non-prefix bytes.
module kbd_shift_track
    import kbd_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_evt,
    input  logic [CODE_W-1:0] code,
    input  logic              rel_pend,
    output logic              is_shift,
    output logic              shift_on
);
    logic [NUM_SHIFT-1:0] held;
    logic [NUM_SHIFT-1:0] hit;

    for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_key
        // Decode this shift key's code
        assign hit[k] = (code == shift_code(k));

        // Update this key's held bit on its own press or release
        always_ff @(posedge clk) begin
            if (!rst_n)                held[k] <= 1'b0;
            else if (key_evt && hit[k]) held[k] <= ~rel_pend;
        end
    end

    // Combine the per-key results
    assign is_shift = |hit;
    assign shift_on = |held;
endmodule

// File: rtl/kbd_ascii_map.sv
// Scan code to ASCII translation, purely combinational.
// Gives lowercase or unshifted values, applies shift to letters and to the
// digit and punctuation keys, and gives 0x00 for extended and unmapped codes.
module kbd_ascii_map
    import kbd_dec_pkg::*;
(
    input  logic               [CODE_W-1:0]  code,
    input  logic                             ext,
    input  logic                             shift,
    output logic               [ASCII_W-1:0] ascii
);
    logic [ASCII_W-1:0] base;
    logic [ASCII_W-1:0] sym;
    logic               letter;

    // Unshifted character for each mapped key
    always_comb begin
        case (code)
            8'h1C: base = "a";  8'h32: base = "b";  8'h21: base = "c";
            8'h23: base = "d";  8'h24: base = "e";  8'h2B: base = "f";
            8'h34: base = "g";  8'h33: base = "h";  8'h43: base = "i";
            8'h3B: base = "j";  8'h42: base = "k";  8'h4B: base = "l";
            8'h3A: base = "m";  8'h31: base = "n";  8'h44: base = "o";
            8'h4D: base = "p";  8'h15: base = "q";  8'h2D: base = "r";
            8'h1B: base = "s";  8'h2C: base = "t";  8'h3C: base = "u";
            8'h2A: base = "v";  8'h1D: base = "w";  8'h22: base = "x";
            8'h35: base = "y";  8'h1A: base = "z";
            8'h16: base = "1";  8'h1E: base = "2";  8'h26: base = "3";
            8'h25: base = "4";  8'h2E: base = "5";  8'h36: base = "6";
            8'h3D: base = "7";  8'h3E: base = "8";  8'h46: base = "9";
            8'h45: base = "0";
            8'h4E: base = "-";  8'h55: base = "=";  8'h41: base = ",";
            8'h49: base = ".";  8'h4A: base = "/";  8'h4C: base = ";";
            8'h29: base = 8'h20;
            8'h0D: base = 8'h09;
            8'h5A: base = 8'h0D;
            8'h66: base = 8'h08;
            8'h76: base = 8'h1B;
            default: base = 8'h00;
        endcase
    end

    // Shifted symbol for non-letter keys, zero when shift changes nothing
    always_comb begin
        case (code)
            8'h16: sym = "!";  8'h1E: sym = "@";  8'h26: sym = "#";
            8'h25: sym = "$";  8'h2E: sym = "%";  8'h36: sym = "^";
            8'h3D: sym = "&";  8'h3E: sym = "*";  8'h46: sym = "(";
            8'h45: sym = ")";  8'h4E: sym = "_";  8'h55: sym = "+";
            8'h41: sym = "<";  8'h49: sym = ">";  8'h4A: sym = "?";
            8'h4C: sym = ":";
            default: sym = 8'h00;
        endcase
    end

    // Letters are shifted arithmetically
    assign letter = (base >= "a") && (base <= "z");

    // Select the final character
    always_comb begin
        if (ext)                   ascii = 8'h00;
        else if (!shift)           ascii = base;
        else if (letter)           ascii = base - CASE_DELTA;
        else if (sym != 8'h00)     ascii = sym;
        else                       ascii = base;
    end
endmodule

// File: rtl/kbd_out_hold.sv
// Output registers and ready handshake.
// Loads the event fields on a strobe. key_ready rises with the strobe and
// falls on read_ack, and a strobe in the same cycle as read_ack wins.
module kbd_out_hold
    import kbd_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic               read_ack,
    input  logic [CODE_W-1:0]  code_in,
    input  logic [ASCII_W-1:0] ascii_in,
    input  logic               ext_in,
    input  logic               rel_in,
    output logic               ready,
    output logic [CODE_W-1:0]  code_out,
    output logic [ASCII_W-1:0] ascii_out,
    output logic               ext_out,
    output logic               rel_out
);
    typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} hs_state_t;
    hs_state_t st;

    // Two-state handshake
    always_ff @(posedge clk) begin
        if (!rst_n)        st <= ST_EMPTY;
        else if (strobe)   st <= ST_FULL;
        else if (read_ack) st <= ST_EMPTY;
    end
    assign ready = (st == ST_FULL);

    // Capture the event fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out  <= '0;
            ascii_out <= '0;
            ext_out   <= 1'b0;
            rel_out   <= 1'b0;
        end else if (strobe) begin
            code_out  <= code_in;
            ascii_out <= ascii_in;
            ext_out   <= ext_in;
            rel_out   <= rel_in;
        end
    end
endmodule

// File: rtl/kbd_scan_decoder.sv
// Top level of the scan code decoder.
// Classifies each valid byte as a prefix or a key event, and routes key
// events to the shift tracker, the ASCII mapper and the output stage.
// TRAP_SHIFT non-zero keeps shift key events off the output.
module kbd_scan_decoder
    import kbd_dec_pkg::*;
#(
    parameter int unsigned TRAP_SHIFT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               code_valid,
    input  logic [CODE_W-1:0]  code_byte,
    input  logic               read_ack,
    output logic               key_ready,
    output logic [CODE_W-1:0]  key_code,
    output logic [ASCII_W-1:0] key_ascii,
    output logic               key_ext,
    output logic               key_rel,
    output logic               shift_on
);
    logic               ext_seen;
    logic               rel_seen;
    logic               key_evt;
    logic               ext_pend;
    logic               rel_pend;
    logic               is_shift;
    logic               out_strobe;
    logic [ASCII_W-1:0] ascii_now;

    // Classify the incoming byte
    assign ext_seen = code_valid && (code_byte == EXT_PREFIX);
    assign rel_seen = code_valid && (code_byte == REL_PREFIX);
    assign key_evt  = code_valid && !ext_seen && !rel_seen;

    kbd_prefix_hold u_prefix (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_seen (ext_seen),
        .rel_seen (rel_seen),
        .key_evt  (key_evt),
        .ext_pend (ext_pend),
        .rel_pend (rel_pend)
    );

    kbd_shift_track u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_evt  (key_evt),
        .code     (code_byte),
        .rel_pend (rel_pend),
        .is_shift (is_shift),
        .shift_on (shift_on)
    );

    kbd_ascii_map u_ascii (
        .code  (code_byte),
        .ext   (ext_pend),
        .shift (shift_on),
        .ascii (ascii_now)
    );

    // Pick the output strobe for the selected trap variant
    if (TRAP_SHIFT != 0) begin : g_trap
        assign out_strobe = key_evt && !is_shift;
    end else begin : g_pass
        assign out_strobe = key_evt;
    end

    kbd_out_hold u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (out_strobe),
        .read_ack  (read_ack),
        .code_in   (code_byte),
        .ascii_in  (ascii_now),
        .ext_in    (ext_pend),
        .rel_in    (rel_pend),
        .ready     (key_ready),
        .code_out  (key_code),
        .ascii_out (key_ascii),
        .ext_out   (key_ext),
        .rel_out   (key_rel)
    );
endmodule

// File: rtl/kbd_scan_decoder_chk.sv
// Assertion checker for kbd_scan_decoder, attached by bind below.
// Watches the port handshake and the prefix and shift state.
module kbd_scan_decoder_chk
    import kbd_dec_pkg::*;
#(
    parameter int unsigned TRAP_SHIFT = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               code_valid,
    input logic [CODE_W-1:0]  code_byte,
    input logic               read_ack,
    input logic               key_ready,
    input logic [CODE_W-1:0]  key_code,
    input logic [ASCII_W-1:0] key_ascii,
    input logic               ext_pend,
    input logic               rel_pend,
    input logic               shift_on
);
    a_r1_ext_prefix_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && code_byte == EXT_PREFIX && !read_ack
        |=> $stable(key_ready) && $stable(key_code) && ext_pend);

    a_r2_rel_prefix_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && code_byte == REL_PREFIX && !read_ack
        |=> $stable(key_ready) && $stable(key_code) && rel_pend);

    a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && code_byte != EXT_PREFIX && code_byte != REL_PREFIX
        |=> !ext_pend && !rel_pend);

    a_r4_shift_press: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && (code_byte == LSHIFT_CODE || code_byte == RSHIFT_CODE) && !rel_pend
        |=> shift_on);

    a_r7_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (TRAP_SHIFT != 0) && code_valid && !read_ack
        && (code_byte == LSHIFT_CODE || code_byte == RSHIFT_CODE)
        |=> $stable(key_ready) && $stable(key_code));

    a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        key_ready && !read_ack |=> key_ready);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        read_ack && !code_valid |=> !key_ready);

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !key_ready && !shift_on && !ext_pend && !rel_pend);

    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> $stable(key_code) && $stable(key_ascii));
endmodule

bind kbd_scan_decoder kbd_scan_decoder_chk #(.TRAP_SHIFT(TRAP_SHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .read_ack   (read_ack),
    .key_ready  (key_ready),
    .key_code   (key_code),
    .key_ascii  (key_ascii),
    .ext_pend   (ext_pend),
    .rel_pend   (rel_pend),
    .shift_on   (shift_on)
);

// File: tb/kbd_scan_decoder_bench.sv
`timescale 1ns/1ps
// Bench for kbd_scan_decoder: one build without trapping (suffix 0) and one
// with trapping (suffix 1), both fed the same byte stream.
module kbd_scan_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic       read_ack = 1'b0;

    logic       rdy0, ext0, rel0, sh0;
    logic [7:0] code0, asc0;
    logic       rdy1, ext1, rel1, sh1;
    logic [7:0] code1, asc1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    kbd_scan_decoder #(.TRAP_SHIFT(0)) u_kbd_scan_decoder (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
        .read_ack(read_ack), .key_ready(rdy0), .key_code(code0), .key_ascii(asc0),
        .key_ext(ext0), .key_rel(rel0), .shift_on(sh0));

    kbd_scan_decoder #(.TRAP_SHIFT(1)) u_kbd_scan_decoder_trap (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
        .read_ack(read_ack), .key_ready(rdy1), .key_code(code1), .key_ascii(asc1),
        .key_ext(ext1), .key_rel(rel1), .shift_on(sh1));

    logic [7:0] letter_code [26];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One byte for one cycle; outputs are visible at the following negedge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        code_byte = b;
        code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        read_ack = 1'b1;
        @(negedge clk);
        read_ack = 1'b0;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        letter_code = '{8'h1C, 8'h32, 8'h21, 8'h23, 8'h24, 8'h2B, 8'h34, 8'h33, 8'h43,
                        8'h3B, 8'h42, 8'h4B, 8'h3A, 8'h31, 8'h44, 8'h4D, 8'h15, 8'h2D,
                        8'h1B, 8'h2C, 8'h3C, 8'h2A, 8'h1D, 8'h22, 8'h35, 8'h1A};
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 ready", rdy0, 0);
        chk("R10 code", code0, 0);
        chk("R10 ascii", asc0, 0);
        chk("R10 shift", sh1, 0);
        rst_n = 1'b1;

        // R3 R5 plain key
        send(8'h1C);
        chk("R9 ready", rdy0, 1);
        chk("R3 code", code0, 8'h1C);
        chk("R5 lower a", asc0, "a");
        chk("R3 ext", ext0, 0);
        chk("R3 rel", rel0, 0);
        ack();
        chk("R9 ack clears", rdy0, 0);

        // R2 release prefix, then key
        send(8'hF0);
        chk("R2 no event", rdy0, 0);
        send(8'h1C);
        chk("R2 rel flag", rel0, 1);
        chk("R2 ascii", asc0, "a");
        ack();

        // R1 extended prefix, R6 extended gives zero
        send(8'hE0);
        chk("R1 no event", rdy0, 0);
        chk("R1 code unchanged", code0, 8'h1C);
        send(8'h11);
        chk("R1 ext flag", ext0, 1);
        chk("R1 code", code0, 8'h11);
        chk("R6 ext ascii zero", asc0, 0);
        ack();
        send(8'h1C);
        chk("R3 ext cleared", ext0, 0);
        ack();

        // Sweep over all bytes: R3 echo, R7 trap suppression, R8 shift visible
        for (int v = 0; v < 256; v++) begin
            if (v == 8'hE0 || v == 8'hF0) continue;
            send(v[7:0]);
            chk("R3 sweep ready", rdy0, 1);
            chk("R8 sweep code", code0, v);
            chk("R7 sweep trap ready", rdy1, (v != 8'h12 && v != 8'h59) ? 1 : 0);
            ack();
        end
        send(8'hF0); send(8'h12);
        send(8'hF0); send(8'h59);
        ack();
        chk("R4 shift released", sh0, 0);
        chk("R4 shift released trap", sh1, 0);

        // R5 all letters unshifted
        for (int i = 0; i < 26; i++) begin
            send(letter_code[i]);
            chk("R5 lower", asc0, 8'h61 + i);
            ack();
        end
        // R4 R5 left shift held
        send(8'h12);
        ack();
        chk("R4 left shift on", sh0, 1);
        chk("R4 left shift on trap", sh1, 1);
        for (int i = 0; i < 26; i++) begin
            send(letter_code[i]);
            chk("R5 upper left", asc0, 8'h41 + i);
            chk("R5 upper left trap", asc1, 8'h41 + i);
            ack();
        end
        send(8'h16);
        chk("R6 shifted digit", asc0, "!");
        ack();
        send(8'hF0); send(8'h12);
        ack();
        chk("R4 left release", sh0, 0);
        // right shift
        send(8'h59);
        ack();
        chk("R4 right shift on", sh1, 1);
        for (int i = 0; i < 26; i += 5) begin
            send(letter_code[i]);
            chk("R5 upper right", asc0, 8'h41 + i);
            ack();
        end
        send(8'hF0); send(8'h59);
        ack();
        chk("R4 right release", sh0, 0);

        // R6 fixed codes
        send(8'h0D); chk("R6 tab", asc0, 8'h09); ack();
        send(8'h5A); chk("R6 enter", asc0, 8'h0D); ack();
        send(8'h29); chk("R6 space", asc0, 8'h20); ack();
        send(8'h16); chk("R6 digit", asc0, "1"); ack();
        send(8'h01); chk("R6 unmapped ascii", asc0, 0);
        chk("R6 unmapped code", code0, 8'h01); ack();

        // Sequence 12 1C F0 1C F0 12 on the non-trapping build (R8)
        send(8'h12);
        chk("R8 shift code", code0, 8'h12);
        chk("R8 shift ascii", asc0, 0);
        chk("R7 trap no event", rdy1, 0);
        ack();
        send(8'h1C); chk("R5 A", asc0, "A"); ack();
        send(8'hF0); send(8'h1C);
        chk("R5 released A", asc0, "A");
        chk("R2 released A flag", rel0, 1);
        ack();
        send(8'hF0); send(8'h12);
        chk("R8 shift release code", code0, 8'h12);
        chk("R8 shift release flag", rel0, 1);
        chk("R7 trap release no event", rdy1, 0);
        chk("R7 trap code held", code1, 8'h1C);
        ack();

        // R7 trapped shift still clears pending prefixes
        send(8'hE0); send(8'hF0); send(8'h12);
        chk("R7 trap suppressed", rdy1, 0);
        send(8'h1C);
        chk("R7 trap ext cleared", ext1, 0);
        chk("R7 trap rel cleared", rel1, 0);
        chk("R3 untrapped ext cleared", ext0, 0);
        ack();

        // R9 ready holds without ack, new data overwrites
        send(8'h1C);
        repeat (3) @(negedge clk);
        chk("R9 hold", rdy0, 1);
        chk("R11 code held", code0, 8'h1C);
        send(8'h32);
        chk("R9 still ready", rdy0, 1);
        chk("R3 overwrite", code0, 8'h32);
        // R9 strobe together with ack keeps ready
        @(negedge clk);
        code_byte = 8'h21; code_valid = 1'b1; read_ack = 1'b1;
        @(negedge clk);
        code_valid = 1'b0; read_ack = 1'b0;
        chk("R9 strobe wins", rdy0, 1);
        chk("R9 strobe wins code", code0, 8'h21);
        ack();
        chk("R9 final ack", rdy0, 0);

        // R10 reset mid-operation
        send(8'h12);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 shift cleared", sh0, 0);
        chk("R10 ready cleared", rdy0, 0);
        chk("R10 code cleared", code0, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule